// File: doc/BRIEF.md
# Condition Flag Update Unit

This block keeps the four condition flags of a 32-bit processor: negative (N), zero (Z), carry (C) and overflow (V). When an instruction retires, the unit decides which flags change and which value each takes. It uses the instruction class, the instruction's set-flags bit, the ALU result, the adder carry and overflow, and the shifter carry-out. Flags that are not updated keep their value for any number of cycles. Nothing clears them automatically.

Two other sources can also write the flags. A direct status write replaces the flags picked by a per-flag mask, using the top four bits of the written word. An exception return reloads all four flags from a saved status word. When more than one source is valid in the same cycle, a fixed priority picks the winner. The register is clocked, with a synchronous active-low reset.

Top module: `cflag_unit`

## Requirements
- R1: With `instr_vld` low and no direct write or exception return, `flags` does not change on the next edge, whatever the other inputs hold, and it keeps its value over any number of such cycles.
- R2: An instruction of class 0 (add/subtract) or class 1 (logical) with `instr_set` = 0 leaves all four flags unchanged.
- R3: Class 2 (compare, compare-negative) and class 3 (test, test-equivalence) update the flags whenever `instr_vld` is high, whatever the value of `instr_set`.
- R4: Every instruction-driven update sets N (`flags[3]`) to result bit 31 and Z (`flags[2]`) to 1 exactly when all 32 result bits are zero.
- R5: For classes 0 and 2, an update sets C (`flags[1]`) to `add_cout` and V (`flags[0]`) to `add_ovf`.
- R6: For classes 1 and 3, an update sets C to `shf_cout` and leaves V at its previous value.
- R7: Class codes 4 to 7 never change the flags, even with `instr_set` = 1.
- R8: A direct write loads each flag whose `dwr_mask` bit is 1 from the written value and leaves the other flags unchanged.
  - The mapping is: mask bit 3 with value bit 31 gives N; mask bit 2 with bit 30 gives Z; mask bit 1 with bit 29 gives C; mask bit 0 with bit 28 gives V.
  - For example, value 0x80000000 with mask 4'b1111 gives `flags` = 4'b1000.
- R9: An exception return loads all four flags from bits 31..28 of `xret_val`.
- R10: Priority between sources is fixed.
  - An exception return wins over a direct write, and a direct write wins over an instruction update.
  - The losing sources have no effect in that cycle.
- R11: With `rst_n` low at a clock edge, `flags` is 4'b0000 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_vld | input | 1 | One-cycle strobe for a retiring instruction |
| instr_cls | input | 3 | Instruction class: 0 add/sub, 1 logical, 2 compare, 3 test, 4-7 no flag effect |
| instr_set | input | 1 | Set-flags bit of the instruction |
| alu_res | input | 32 | ALU result |
| add_cout | input | 1 | Adder carry-out |
| add_ovf | input | 1 | Adder signed overflow |
| shf_cout | input | 1 | Barrel-shifter carry-out |
| dwr_vld | input | 1 | Direct status write strobe |
| dwr_val | input | 32 | Direct write value; bits 31..28 carry N, Z, C, V |
| dwr_mask | input | 4 | Per-flag write select (bit 3 N ... bit 0 V) |
| xret_vld | input | 1 | Exception-return restore strobe |
| xret_val | input | 32 | Saved status value; bits 31..28 restored |
| flags | output | 4 | Current flags {N, Z, C, V} |

## Verification
The bench builds the unit with its default `DATA_W` of 32. At that width the Z detection spans the full result word, and N, together with both write sources, comes from bits 31..28. This brings 0x80000000 and an all-zero result within reach as the two N/Z extremes. The random phase drives every class code with and without the set-flags bit. It mixes in overlapping direct writes and exception returns with arbitrary masks, so each priority pairing and each partial-mask merge occurs against a persisting V flag.

// File: rtl/cflag_pkg.sv
// Package: shared types for the condition flag update unit.
// Assumes flags are ordered {N, Z, C, V} from bit 3 down to bit 0.
package cflag_pkg;

    localparam int FLAG_CNT = 4;
    localparam int IDX_N    = 3;
    localparam int IDX_Z    = 2;
    localparam int IDX_C    = 1;
    localparam int IDX_V    = 0;

    typedef logic [FLAG_CNT-1:0] flags_t;

    // Instruction classes as seen by the flag logic
    typedef enum logic [2:0] {
        CLS_ARITH = 3'd0,
        CLS_LOGIC = 3'd1,
        CLS_CMP   = 3'd2,
        CLS_TST   = 3'd3,
        CLS_NONE  = 3'd4
    } cls_e;

endpackage

// File: rtl/cflag_instr_eval.sv
// Module: cflag_instr_eval
// Works out whether a retiring instruction updates the flags, and the
// resulting flag vector. Assumes the ALU signals are valid in the strobe
// cycle. Overflow is carried over from cur_i for logical-type classes.
module cflag_instr_eval
    import cflag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              vld_i,
    input  logic [2:0]        cls_i,
    input  logic              set_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              add_c_i,
    input  logic              add_v_i,
    input  logic              sh_c_i,
    input  flags_t            cur_i,
    output logic              upd_o,
    output flags_t            nxt_o
);

    cls_e cls;
    logic upd_raw;
    logic use_adder;

    assign cls = cls_e'(cls_i);

    // Decode the update request and the carry/overflow source from the class
    always_comb begin
        upd_raw   = 1'b0;
        use_adder = 1'b0;
        case (cls)
            CLS_ARITH: begin upd_raw = set_i; use_adder = 1'b1; end
            CLS_LOGIC: begin upd_raw = set_i; use_adder = 1'b0; end
            CLS_CMP:   begin upd_raw = 1'b1;  use_adder = 1'b1; end
            CLS_TST:   begin upd_raw = 1'b1;  use_adder = 1'b0; end
            default:   begin upd_raw = 1'b0;  use_adder = 1'b0; end
        endcase
    end

    assign upd_o = vld_i & upd_raw;

    // Build the per-flag result values
    always_comb begin
        nxt_o        = cur_i;
        nxt_o[IDX_N] = res_i[DATA_W-1];
        nxt_o[IDX_Z] = ~|res_i;
        nxt_o[IDX_C] = use_adder ? add_c_i : sh_c_i;
        nxt_o[IDX_V] = use_adder ? add_v_i : cur_i[IDX_V];
    end

endmodule

// File: rtl/cflag_src_mux.sv
// Module: cflag_src_mux
// Picks the next flag value from three sources with fixed priority:
// exception-return restore, then direct write, then instruction update.
// Assumes the write fields are already cut down to the top four bits.
module cflag_src_mux
    import cflag_pkg::*;
(
    input  logic   xret_vld_i,
    input  flags_t xret_fld_i,
    input  logic   dwr_vld_i,
    input  flags_t dwr_fld_i,
    input  flags_t dwr_mask_i,
    input  logic   ins_upd_i,
    input  flags_t ins_nxt_i,
    input  flags_t cur_i,
    output logic   ld_o,
    output flags_t nxt_o
);

    flags_t dwr_merged;

    // Per-flag merge of the direct write under its mask
    for (genvar g = 0; g < FLAG_CNT; g++) begin : g_dwr
        assign dwr_merged[g] = dwr_mask_i[g] ? dwr_fld_i[g] : cur_i[g];
    end

    // Priority select among the write sources
    always_comb begin
        if (xret_vld_i) begin
            ld_o  = 1'b1;
            nxt_o = xret_fld_i;
        end else if (dwr_vld_i) begin
            ld_o  = 1'b1;
            nxt_o = dwr_merged;
        end else begin
            ld_o  = ins_upd_i;
            nxt_o = ins_nxt_i;
        end
    end

endmodule

// File: rtl/cflag_reg.sv
// Module: cflag_reg
// Flag storage register with load enable and synchronous active-low reset
// to all zeros. Holds its value indefinitely while ld_i is low.
module cflag_reg
    import cflag_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ld_i,
    input  flags_t d_i,
    output flags_t q_o
);

    // Store the flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (ld_i) begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/cflag_unit.sv
// Module: cflag_unit (top)
// Condition flag update unit. It takes an instruction-driven update, a
// masked direct status write and an exception-return restore. It keeps
// {N, Z, C, V}. Assumes each strobe is a one-cycle pulse and that the
// flag fields sit in the top four bits of the write words.
module cflag_unit
    import cflag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_vld,
    input  logic [2:0]        instr_cls,
    input  logic              instr_set,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              add_cout,
    input  logic              add_ovf,
    input  logic              shf_cout,
    input  logic              dwr_vld,
    input  logic [DATA_W-1:0] dwr_val,
    input  logic [3:0]        dwr_mask,
    input  logic              xret_vld,
    input  logic [DATA_W-1:0] xret_val,
    output logic [3:0]        flags
);

    localparam int FLD_LO = DATA_W - FLAG_CNT;

    flags_t cur;
    flags_t ins_nxt;
    flags_t sel_nxt;
    logic   ins_upd;
    logic   sel_ld;
    logic   unused_low;

    // Lower word bits carry no flag information
    assign unused_low = ^{dwr_val[FLD_LO-1:0], xret_val[FLD_LO-1:0]};

    cflag_instr_eval #(.DATA_W(DATA_W)) u_eval (
        .vld_i   (instr_vld),
        .cls_i   (instr_cls),
        .set_i   (instr_set),
        .res_i   (alu_res),
        .add_c_i (add_cout),
        .add_v_i (add_ovf),
        .sh_c_i  (shf_cout),
        .cur_i   (cur),
        .upd_o   (ins_upd),
        .nxt_o   (ins_nxt)
    );

    cflag_src_mux u_mux (
        .xret_vld_i (xret_vld),
        .xret_fld_i (xret_val[DATA_W-1:FLD_LO]),
        .dwr_vld_i  (dwr_vld),
        .dwr_fld_i  (dwr_val[DATA_W-1:FLD_LO]),
        .dwr_mask_i (dwr_mask),
        .ins_upd_i  (ins_upd),
        .ins_nxt_i  (ins_nxt),
        .cur_i      (cur),
        .ld_o       (sel_ld),
        .nxt_o      (sel_nxt)
    );

    cflag_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_i  (sel_ld),
        .d_i   (sel_nxt),
        .q_o   (cur)
    );

    assign flags = cur;

endmodule

// File: rtl/cflag_unit_chk.sv
// Module: cflag_unit_chk
// Assertion checker for cflag_unit. It is attached with bind and observes
// ports only. Assumes the class encoding given in the brief.
module cflag_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_vld,
    input logic [2:0]        instr_cls,
    input logic              instr_set,
    input logic [DATA_W-1:0] alu_res,
    input logic              add_cout,
    input logic              add_ovf,
    input logic              shf_cout,
    input logic              dwr_vld,
    input logic [DATA_W-1:0] dwr_val,
    input logic [3:0]        dwr_mask,
    input logic              xret_vld,
    input logic [DATA_W-1:0] xret_val,
    input logic [3:0]        flags
);

    logic ins_add;
    logic ins_log;
    logic ins_only;
    logic quiet;

    // Classify the observed request at the ports
    assign ins_add  = instr_vld && (instr_cls == 3'd2 || (instr_cls == 3'd0 && instr_set));
    assign ins_log  = instr_vld && (instr_cls == 3'd3 || (instr_cls == 3'd1 && instr_set));
    assign ins_only = !xret_vld && !dwr_vld;
    assign quiet    = ins_only && !ins_add && !ins_log;

    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> flags == 4'b0000); // R11
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> $stable(flags)); // R1
    AST_XRET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        xret_vld |=> flags == $past(xret_val[DATA_W-1 -: 4])); // R9
    AST_DWR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!xret_vld && dwr_vld) |=> ((flags ^ $past(flags)) & ~$past(dwr_mask)) == 4'b0000); // R8
    AST_DWR_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!xret_vld && dwr_vld) |=> (flags & $past(dwr_mask)) == ($past(dwr_val[DATA_W-1 -: 4]) & $past(dwr_mask))); // R10
    AST_INS_NZ: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_only && (ins_add || ins_log)) |=> (flags[3] == $past(alu_res[DATA_W-1])) && (flags[2] == ($past(alu_res) == '0))); // R4
    AST_ADD_CV: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_only && ins_add) |=> flags[1:0] == {$past(add_cout), $past(add_ovf)}); // R5
    AST_LOG_CV: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_only && ins_log) |=> (flags[1] == $past(shf_cout)) && (flags[0] == $past(flags[0]))); // R6

endmodule

bind cflag_unit cflag_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cflag_unit_bench.sv
`timescale 1ns/1ps
module cflag_unit_bench;

    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              instr_vld = 1'b0;
    logic [2:0]        instr_cls = 3'd0;
    logic              instr_set = 1'b0;
    logic [DATA_W-1:0] alu_res = '0;
    logic              add_cout = 1'b0;
    logic              add_ovf = 1'b0;
    logic              shf_cout = 1'b0;
    logic              dwr_vld = 1'b0;
    logic [DATA_W-1:0] dwr_val = '0;
    logic [3:0]        dwr_mask = 4'b0;
    logic              xret_vld = 1'b0;
    logic [DATA_W-1:0] xret_val = '0;
    logic [3:0]        flags;

    int     n_chk = 0;
    int     n_fail = 0;
    bit     done = 1'b0;
    bit [3:0] mdl = 4'b0;

    always #2 clk = ~clk;

    cflag_unit #(.DATA_W(DATA_W)) u_cflag_unit (.*);

    task automatic check(string tag, logic [3:0] exp);
        n_chk++;
        if (flags !== exp) begin
            n_fail++;
            $display("FAIL %s: flags=%b expected=%b at %0t", tag, flags, exp, $time);
        end
    endtask

    // Drive one cycle, advance the reference model, compare after the edge
    task automatic step(string tag, bit iv, bit [2:0] cl, bit sf, bit [31:0] res,
                        bit ac, bit av, bit sc, bit dv, bit [31:0] dval,
                        bit [3:0] dm, bit xv, bit [31:0] xval);
        bit [3:0] exp;
        @(negedge clk);
        instr_vld = iv; instr_cls = cl; instr_set = sf; alu_res = res;
        add_cout = ac; add_ovf = av; shf_cout = sc;
        dwr_vld = dv; dwr_val = dval; dwr_mask = dm;
        xret_vld = xv; xret_val = xval;
        exp = mdl;
        if (xv) exp = xval[31:28];
        else if (dv) begin
            for (int i = 0; i < 4; i++) if (dm[i]) exp[i] = dval[28+i];
        end else if (iv && (cl == 3'd2 || cl == 3'd3 || (cl < 3'd2 && sf))) begin
            exp[3] = res[31];
            exp[2] = (res == 32'd0);
            if (cl == 3'd0 || cl == 3'd2) begin exp[1] = ac; exp[0] = av; end
            else exp[1] = sc;
        end
        @(posedge clk); #1;
        mdl = exp;
        check(tag, exp);
    endtask

    task automatic do_reset(string tag);
        @(negedge clk);
        rst_n = 1'b0;
        instr_vld = 1'b0; dwr_vld = 1'b0; xret_vld = 1'b0;
        @(posedge clk); #1;
        mdl = 4'b0;
        check(tag, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        string tg;
        do_reset("R11 initial reset");
        // R4 R5: add with zero result and carry/overflow set
        step("R4/R5 add zero", 1, 0, 1, 32'h0, 1, 1, 0, 0, 0, 0, 0, 0);
        // R1: strobe low, other inputs busy
        step("R1 strobe low", 0, 1, 1, 32'h8000_0000, 0, 0, 0, 0, 0, 0, 0, 0);
        // R2: set-flags bit clear
        step("R2 arith no set", 1, 0, 0, 32'h8000_0000, 0, 0, 1, 0, 0, 0, 0, 0);
        step("R2 logic no set", 1, 1, 0, 32'h8000_0000, 0, 0, 0, 0, 0, 0, 0, 0);
        // R6: logical op, V held at 1
        step("R6 logic shifter carry", 1, 1, 1, 32'h8000_0000, 1, 0, 0, 0, 0, 0, 0, 0);
        // R3 R5: compare without set bit
        step("R3/R5 compare", 1, 2, 0, 32'h5, 1, 0, 1, 0, 0, 0, 0, 0);
        // R3 R6: test without set bit, V held at 0
        step("R3/R6 test", 1, 3, 0, 32'h0, 0, 1, 1, 0, 0, 0, 0, 0);
        // R7: unused class codes
        step("R7 class 4", 1, 4, 1, 32'h8000_0000, 0, 1, 0, 0, 0, 0, 0, 0);
        step("R7 class 7", 1, 7, 1, 32'h1, 1, 1, 0, 0, 0, 0, 0, 0);
        // R1: long persistence
        for (int i = 0; i < 20; i++) idle("R1 persist");
        // R8: full and partial direct writes
        step("R8 full write", 0, 0, 0, 0, 0, 0, 0, 1, 32'h8000_0000, 4'b1111, 0, 0);
        step("R8 partial write", 0, 0, 0, 0, 0, 0, 0, 1, 32'h7000_0000, 4'b0101, 0, 0);
        step("R8 empty mask", 0, 0, 0, 0, 0, 0, 0, 1, 32'hF000_0000, 4'b0000, 0, 0);
        // R10: direct write beats instruction
        step("R10 dwr over instr", 1, 2, 1, 32'h0, 1, 1, 1, 1, 32'h2000_0000, 4'b0010, 0, 0);
        // R9 R10: restore beats both
        step("R9/R10 xret over all", 1, 0, 1, 32'h0, 1, 1, 1, 1, 32'hF000_0000, 4'b1111, 1, 32'h5000_0000);
        step("R9 xret zero", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0FFF_FFFF);
        step("R9 xret ones", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hF000_0000);
        do_reset("R11 mid-run reset");
        // Random mix compared every cycle
        for (int i = 0; i < 600; i++) begin
            bit iv, dv, xv, sf;
            bit [2:0] cl;
            iv = ($urandom % 4) != 0;
            dv = ($urandom % 6) == 0;
            xv = ($urandom % 10) == 0;
            sf = $urandom % 2;
            cl = 3'($urandom % 8);
            if (xv) tg = "R9 random";
            else if (dv) tg = "R8 random";
            else if (!iv) tg = "R1 random";
            else if (cl > 3) tg = "R7 random";
            else if (cl == 0 || cl == 2) tg = "R5 random";
            else tg = "R6 random";
            step(tg, iv, cl, sf, (($urandom % 4) == 0) ? 32'h0 : $urandom,
                 1'($urandom), 1'($urandom), 1'($urandom),
                 dv, $urandom, 4'($urandom), xv, $urandom);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule